// File: doc/BRIEF.md
# Field Memory Read Address Controller

This block produces the line and pixel read addresses for one serial read port of a field memory. One read clock drives it, and every control input is sampled on that clock's rising edge. The memory array is outside the block. The block holds only the live read pointers, a stored pixel start address and the flag that enables the data outputs.

Each clock cycle is one of three kinds. In a pointer-reset cycle (`ptr_reset` high), the live pointers get a one-clock repositioning. The pixel pointer is cleared or reloaded from the stored start value, and the line pointer can step by one. In an address-set cycle (`addr_load` high, `ptr_reset` low), the supplied start addresses are captured. In all other cycles, serial reading continues. The input `en_mode` has two roles. Outside reset cycles it gates the pixel increment and the output enable. Inside a reset cycle it chooses the pixel reset target.

The line start value supplied in an address-set cycle is written straight into the live line pointer. The pixel start value goes into a holding register and reaches the pixel pointer only through a reload reset.

Top module: `fm_read_addr_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, `line_addr`, `pix_addr`, `out_en` and the stored pixel start are all cleared to 0. A reload reset that follows gives pixel 0.
- R2: In a cycle with `ptr_reset` low and `en_mode` high, `pix_addr` advances by one at the clock edge.
- R3: In a cycle with `ptr_reset` low and `en_mode` low, `pix_addr` keeps its value.
- R4: After each edge, `out_en` equals 1 only if that edge sampled `ptr_reset` low and `en_mode` high. After a reset cycle it is 0.
- R5: In a cycle with `addr_load` high and `ptr_reset` low, `line_addr` takes `line_in` and `pix_in` is stored as the pixel start. In that cycle the pixel pointer behaves as in R2 and R3.
- R6: A reset cycle with `en_mode` low sets `pix_addr` to 0.
- R7: A reset cycle with `en_mode` high sets `pix_addr` to the stored pixel start.
- R8: A reset cycle with `line_step` high advances `line_addr` by one. With `line_step` low, `line_addr` is unchanged.
- R9: A reset cycle takes priority over an address-set cycle. When `ptr_reset` and `addr_load` are both high, neither the stored pixel start nor `line_in` is taken.
- R10: `pix_addr` wraps from `LAST_PIX` (default 719) to 0, and `line_addr` wraps from `LAST_LINE` (default 287) to 0.
- R11: Outside reset cycles, `line_step` has no effect. `line_addr` changes only through an address-set load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Read clock, rising edge active |
| rst | input | 1 | Synchronous active-high global reset |
| en_mode | input | 1 | Read enable outside reset cycles; pixel reset mode inside them (0 = zero, 1 = reload) |
| addr_load | input | 1 | Address-set strobe |
| ptr_reset | input | 1 | Pointer-reset strobe |
| line_step | input | 1 | Line advance request, honoured only in reset cycles |
| line_in | input | LINE_W | Line start address for address-set cycles |
| pix_in | input | PIX_W | Pixel start address for address-set cycles |
| line_addr | output | LINE_W | Current read line address |
| pix_addr | output | PIX_W | Current read pixel address |
| out_en | output | 1 | Data-output enable |

## Verification
A corrupted stored pixel start cannot be seen until a reload reset: `pix_addr` then shows the wrong value on the very next edge. The bench therefore follows every address-set and priority case with a reload reset. A wrong pointer update shows up on `pix_addr` or `line_addr` one edge after the cycle that caused it. The wrap points can only be seen by driving the pointers up to `LAST_PIX` and `LAST_LINE`. A wrong cycle decode leaves `out_en` wrong one edge after any reset cycle.

// File: rtl/fmrd_pkg.sv
package fmrd_pkg;

    typedef enum logic [1:0] {
        CYC_NORMAL = 2'd0,
        CYC_SET    = 2'd1,
        CYC_RESET  = 2'd2
    } cycle_e;

    typedef struct packed {
        logic pix_clear;
        logic pix_reload;
        logic pix_step;
        logic line_load;
        logic line_adv;
        logic start_load;
        logic oe_next;
    } ctl_t;

    function automatic cycle_e classify(input logic rst_strobe, input logic set_strobe);
        if (rst_strobe)
            return CYC_RESET;
        else if (set_strobe)
            return CYC_SET;
        else
            return CYC_NORMAL;
    endfunction

endpackage

// File: rtl/fmrd_decode.sv
module fmrd_decode
    import fmrd_pkg::*;
(
    input  logic en_mode,
    input  logic addr_load,
    input  logic ptr_reset,
    input  logic line_step,
    output ctl_t ctl
);
    cycle_e kind;

    always_comb begin
        kind = classify(ptr_reset, addr_load);
        ctl  = '0;
        unique case (kind)
            CYC_RESET: begin
                ctl.pix_clear  = ~en_mode;
                ctl.pix_reload = en_mode;
                ctl.line_adv   = line_step;
            end
            CYC_SET: begin
                ctl.pix_step   = en_mode;
                ctl.line_load  = 1'b1;
                ctl.start_load = 1'b1;
                ctl.oe_next    = en_mode;
            end
            default: begin
                ctl.pix_step   = en_mode;
                ctl.oe_next    = en_mode;
            end
        endcase
    end
endmodule

// File: rtl/fmrd_wrap_ctr.sv
module fmrd_wrap_ctr #(
    parameter int W    = 10,
    parameter int LAST = 719
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] END_VAL = W'(LAST);

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (clear)
            q <= '0;
        else if (load)
            q <= load_val;
        else if (step)
            q <= (q == END_VAL) ? '0 : q + W'(1);
    end
endmodule

// File: rtl/fmrd_start_reg.sv
module fmrd_start_reg #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (load)
            q <= d;
    end
endmodule

// File: rtl/fm_read_addr_ctrl.sv
module fm_read_addr_ctrl
    import fmrd_pkg::*;
#(
    parameter int LINE_W    = 9,
    parameter int PIX_W     = 10,
    parameter int LAST_LINE = 287,
    parameter int LAST_PIX  = 719
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_mode,
    input  logic              addr_load,
    input  logic              ptr_reset,
    input  logic              line_step,
    input  logic [LINE_W-1:0] line_in,
    input  logic [PIX_W-1:0]  pix_in,
    output logic [LINE_W-1:0] line_addr,
    output logic [PIX_W-1:0]  pix_addr,
    output logic              out_en
);
    ctl_t             ctl;
    logic [PIX_W-1:0] start_pix;

    fmrd_decode u_dec (
        .en_mode   (en_mode),
        .addr_load (addr_load),
        .ptr_reset (ptr_reset),
        .line_step (line_step),
        .ctl       (ctl)
    );

    fmrd_start_reg #(.W(PIX_W)) u_start (
        .clk  (clk),
        .rst  (rst),
        .load (ctl.start_load),
        .d    (pix_in),
        .q    (start_pix)
    );

    fmrd_wrap_ctr #(.W(PIX_W), .LAST(LAST_PIX)) u_pix (
        .clk      (clk),
        .rst      (rst),
        .clear    (ctl.pix_clear),
        .load     (ctl.pix_reload),
        .load_val (start_pix),
        .step     (ctl.pix_step),
        .q        (pix_addr)
    );

    fmrd_wrap_ctr #(.W(LINE_W), .LAST(LAST_LINE)) u_line (
        .clk      (clk),
        .rst      (rst),
        .clear    (1'b0),
        .load     (ctl.line_load),
        .load_val (line_in),
        .step     (ctl.line_adv),
        .q        (line_addr)
    );

    always_ff @(posedge clk) begin
        if (rst)
            out_en <= 1'b0;
        else
            out_en <= ctl.oe_next;
    end
endmodule

// File: rtl/fmrd_chk.sv
module fmrd_chk #(
    parameter int LINE_W    = 9,
    parameter int PIX_W     = 10,
    parameter int LAST_LINE = 287,
    parameter int LAST_PIX  = 719
) (
    input logic              clk,
    input logic              rst,
    input logic              en_mode,
    input logic              addr_load,
    input logic              ptr_reset,
    input logic              line_step,
    input logic [LINE_W-1:0] line_in,
    input logic [LINE_W-1:0] line_addr,
    input logic [PIX_W-1:0]  pix_addr,
    input logic [PIX_W-1:0]  start_pix,
    input logic              out_en
);
    localparam logic [PIX_W-1:0]  PIX_END  = PIX_W'(LAST_PIX);
    localparam logic [LINE_W-1:0] LINE_END = LINE_W'(LAST_LINE);

    // R1
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (pix_addr == '0 && line_addr == '0 && !out_en && start_pix == '0));

    // R2 R10
    pix_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!ptr_reset && en_mode) |=>
            pix_addr == (($past(pix_addr) == PIX_END) ? '0 : $past(pix_addr) + PIX_W'(1)));

    // R3
    pix_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ptr_reset && !en_mode) |=> $stable(pix_addr));

    // R4
    oe_follow_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (out_en == $past(!ptr_reset && en_mode)));

    // R5
    line_set_chk: assert property (@(posedge clk) disable iff (rst)
        (addr_load && !ptr_reset) |=> (line_addr == $past(line_in)));

    // R6
    pix_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (ptr_reset && !en_mode) |=> (pix_addr == '0));

    // R7
    pix_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (ptr_reset && en_mode) |=> (pix_addr == $past(start_pix)));

    // R8 R10
    line_adv_chk: assert property (@(posedge clk) disable iff (rst)
        (ptr_reset && line_step) |=>
            line_addr == (($past(line_addr) == LINE_END) ? '0 : $past(line_addr) + LINE_W'(1)));

    // R8
    line_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (ptr_reset && !line_step) |=> $stable(line_addr));

    // R9
    start_keep_chk: assert property (@(posedge clk) disable iff (rst)
        ptr_reset |=> $stable(start_pix));

    // R11
    line_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!ptr_reset && !addr_load) |=> $stable(line_addr));
endmodule

bind fm_read_addr_ctrl fmrd_chk #(
    .LINE_W(LINE_W), .PIX_W(PIX_W), .LAST_LINE(LAST_LINE), .LAST_PIX(LAST_PIX)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .en_mode   (en_mode),
    .addr_load (addr_load),
    .ptr_reset (ptr_reset),
    .line_step (line_step),
    .line_in   (line_in),
    .line_addr (line_addr),
    .pix_addr  (pix_addr),
    .start_pix (start_pix),
    .out_en    (out_en)
);

// File: tb/fm_read_addr_ctrl_test.sv
`timescale 1ns/1ps
module fm_read_addr_ctrl_test;
    localparam int LW = 9;
    localparam int PW = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en_mode = 1'b0;
    logic          addr_load = 1'b0;
    logic          ptr_reset = 1'b0;
    logic          line_step = 1'b0;
    logic [LW-1:0] line_in = '0;
    logic [PW-1:0] pix_in = '0;
    logic [LW-1:0] line_addr;
    logic [PW-1:0] pix_addr;
    logic          out_en;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #10 clk = ~clk;

    fm_read_addr_ctrl uut (
        .clk(clk), .rst(rst), .en_mode(en_mode), .addr_load(addr_load),
        .ptr_reset(ptr_reset), .line_step(line_step), .line_in(line_in),
        .pix_in(pix_in), .line_addr(line_addr), .pix_addr(pix_addr), .out_en(out_en)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(input bit en, input bit ld, input bit rs, input bit ls);
        en_mode = en; addr_load = ld; ptr_reset = rs; line_step = ls;
        tick();
        en_mode = 1'b0; addr_load = 1'b0; ptr_reset = 1'b0; line_step = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        tick(); tick();
        check("R1 pix", int'(pix_addr), 0);
        check("R1 line", int'(line_addr), 0);
        check("R1 oe", int'(out_en), 0);
        rst = 1'b0;
        drive(1, 0, 1, 0);
        check("R1 start cleared", int'(pix_addr), 0);
    endtask

    task automatic t_increment();
        for (int i = 0; i < 5; i++) drive(1, 0, 0, 0);
        en_mode = 1'b1;
        check("R2 pix after 5", int'(pix_addr), 5);
        check("R4 oe high", int'(out_en), 1);
        check("R2 line unchanged", int'(line_addr), 0);
        en_mode = 1'b0;
    endtask

    task automatic t_hold();
        for (int i = 0; i < 3; i++) drive(0, 0, 0, 0);
        check("R3 pix held", int'(pix_addr), 5);
        check("R3 oe low", int'(out_en), 0);
    endtask

    task automatic t_set_reload();
        line_in = 9'd17; pix_in = 10'd100;
        drive(0, 1, 0, 0);
        check("R5 line loaded", int'(line_addr), 17);
        check("R5 pix held during set", int'(pix_addr), 5);
        drive(1, 0, 0, 0); drive(1, 0, 0, 0);
        check("R2 pix 7", int'(pix_addr), 7);
        drive(1, 0, 1, 0);
        check("R7 reload", int'(pix_addr), 100);
        check("R4 oe after reset", int'(out_en), 0);
        check("R8 line kept", int'(line_addr), 17);
    endtask

    task automatic t_zero();
        for (int i = 0; i < 3; i++) drive(1, 0, 0, 0);
        check("R2 pix 103", int'(pix_addr), 103);
        drive(0, 0, 1, 0);
        check("R6 zero", int'(pix_addr), 0);
    endtask

    task automatic t_line_step();
        drive(0, 0, 1, 1);
        check("R8 line step", int'(line_addr), 18);
        check("R6 pix zero", int'(pix_addr), 0);
        drive(1, 0, 0, 1);
        check("R11 line ignores step", int'(line_addr), 18);
        check("R2 pix 1", int'(pix_addr), 1);
    endtask

    task automatic t_priority();
        line_in = 9'd200; pix_in = 10'd300;
        drive(1, 1, 1, 0);
        check("R9 pix old start", int'(pix_addr), 100);
        check("R9 line not loaded", int'(line_addr), 18);
        drive(1, 0, 1, 0);
        check("R9 start kept", int'(pix_addr), 100);
    endtask

    task automatic t_wrap();
        line_in = 9'd287; pix_in = 10'd715;
        drive(0, 1, 0, 0);
        drive(1, 0, 1, 0);
        check("R7 reload 715", int'(pix_addr), 715);
        for (int i = 0; i < 4; i++) drive(1, 0, 0, 0);
        check("R10 pix at last", int'(pix_addr), 719);
        drive(1, 0, 0, 0);
        check("R10 pix wrap", int'(pix_addr), 0);
        check("R10 line at last", int'(line_addr), 287);
        drive(0, 0, 1, 1);
        check("R10 line wrap", int'(line_addr), 0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_increment();
        t_hold();
        t_set_reload();
        t_zero();
        t_line_step();
        t_priority();
        t_wrap();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule